// File: doc/BRIEF.md
# Dual-Mode PWM Compare Output Unit

This unit holds one counter and two compare channels, A and B, each with its own waveform pin. A 4-bit waveform-mode input picks one of three counting schemes. In the plain (non-PWM) scheme the counter counts up to TOP and wraps. In the single-slope scheme it also counts up from zero to TOP and wraps, and the pins are set or cleared at the bottom of the ramp. In the dual-slope scheme it climbs to TOP and falls back to zero, and the pin changes on matches on the way up and on the way down.

Each channel has a 2-bit output-action code. What a code does depends on the scheme and, for toggling, on channel identity and the exact mode value. A per-channel drive flag shows whether the current settings make the unit own the pin. A force strobe per channel applies the match action in plain mode without touching the counter. All pins and counter state are registered: an event seen on the current count shows up on the pins one clock later.

Top module: `pwm_cmp_unit`

## Requirements
- R1: While `rst_n` is low, `count` is 0, `count_down` is 0 and both pins are 0.
- R2: Mode groups: single-slope for modes 5, 6, 7, 15; dual-slope for modes 1, 2, 3, 8, 9, 10, 11, 14; plain for all others. In plain and single-slope the count steps up by one each clock and goes to 0 on the clock after it equals `top_val`. In dual-slope it counts up until it equals `top_val`, then down until it equals 0, then up again (top 3 from reset gives 1,2,3,2,1,0,1). `count_down` is 1 while falling, and it flips on the same clock edge as the count leaves an extreme.
- R3: Single-slope, action 2: a match clears the pin and count 0 sets it. Action 3 does the opposite. When both happen in one cycle (compare value 0), the match action wins.
- R4: Single-slope, action 1: channel A toggles on each match only when the mode is 15. In every other mode, and always on channel B, the pin is not driven.
- R5: Action 0 never drives the pin. Whenever a pin is not driven, its level holds.
- R6: Dual-slope, action 2: a match while rising clears the pin and a match while falling sets it. Action 3 does the reverse. A match at an extreme uses the direction in force before the reversal.
- R7: Dual-slope, action 1: channel A toggles on matches only in modes 9 and 14. Otherwise, and always on channel B, the pin is not driven.
- R8: With action 2 or 3 and a compare value equal to `top_val`, matches are ignored. At count 0 the pin takes the bottom action: set for action 2, clear for action 3. In dual-slope mode this is the falling-match action.
- R9: Plain mode, either channel: on a match, action 1 toggles, 2 clears and 3 sets the pin.
- R10: In plain mode a force strobe applies the channel's match action on the next clock and leaves the counter stepping normally. In the PWM schemes the strobe has no effect.
- R11: `drive_a`/`drive_b` are 1 exactly when the pin is driven. That means action 2 or 3 in any mode; action 1 in plain mode; action 1 on channel A in the toggle modes of R4 and R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wave_mode | input | 4 | Waveform mode, grouped as in R2 |
| top_val | input | W | Count ceiling TOP |
| cmp_a | input | W | Channel A compare value |
| cmp_b | input | W | Channel B compare value |
| act_a | input | 2 | Channel A output-action code |
| act_b | input | 2 | Channel B output-action code |
| force_a | input | 1 | Channel A force strobe |
| force_b | input | 1 | Channel B force strobe |
| pin_a | output | 1 | Channel A waveform |
| pin_b | output | 1 | Channel B waveform |
| drive_a | output | 1 | Channel A pin is driven |
| drive_b | output | 1 | Channel B pin is driven |
| count | output | W | Current count |
| count_down | output | 1 | Dual-slope falling direction |

## Verification
A counter or direction flag that goes wrong shows up on `count` and `count_down` on the very next clock. A wrong direction inverts a dual-slope pin at the next match, within one ramp. A bad action decode puts a pin at the wrong level one clock after the match or count-zero event that exposed it. A missing hold or gating fault appears as a pin edge while its drive flag is low. Every mode and action pair in the table is compared against an independent cycle model on every clock, so any divergence is caught within one counter period.

// File: rtl/pwm_cmp_pkg.sv
package pwm_cmp_pkg;

  typedef enum logic [1:0] {SCH_PLAIN, SCH_SINGLE, SCH_DUAL} scheme_e;
  typedef enum logic [1:0] {ACT_NONE, ACT_SET, ACT_CLR, ACT_TGL} act_e;

  function automatic scheme_e scheme_of(input logic [3:0] mode);
    case (mode)
      4'd5, 4'd6, 4'd7, 4'd15: scheme_of = SCH_SINGLE;
      4'd1, 4'd2, 4'd3, 4'd8, 4'd9, 4'd10, 4'd11, 4'd14: scheme_of = SCH_DUAL;
      default: scheme_of = SCH_PLAIN;
    endcase
  endfunction

  // may action code 1 toggle this channel in this mode
  function automatic logic toggle_ok(input scheme_e s, input logic [3:0] mode,
                                     input logic is_a);
    case (s)
      SCH_SINGLE: toggle_ok = is_a && (mode == 4'd15);
      SCH_DUAL:   toggle_ok = is_a && (mode == 4'd9 || mode == 4'd14);
      default:    toggle_ok = 1'b1;
    endcase
  endfunction

  function automatic logic drives(input scheme_e s, input logic [3:0] mode,
                                  input logic is_a, input logic [1:0] act);
    if (act == 2'd0)     drives = 1'b0;
    else if (act[1])     drives = 1'b1;
    else                 drives = toggle_ok(s, mode, is_a);
  endfunction

  function automatic logic apply_act(input logic pin, input act_e a);
    case (a)
      ACT_SET: apply_act = 1'b1;
      ACT_CLR: apply_act = 1'b0;
      ACT_TGL: apply_act = ~pin;
      default: apply_act = pin;
    endcase
  endfunction

endpackage

// File: rtl/pwm_cmp_counter.sv
module pwm_cmp_counter
  import pwm_cmp_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  scheme_e      scheme_i,
  input  logic [W-1:0] top_i,
  output logic [W-1:0] cnt_o,
  output logic         down_o
);
  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};
  localparam logic [W-1:0] ZERO = '0;

  logic [W-1:0] cnt_q;
  logic         down_q;
  logic         at_top, at_bot;

  assign at_top = (cnt_q >= top_i);
  assign at_bot = (cnt_q == ZERO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= ZERO;
      down_q <= 1'b0;
    end else if (scheme_i == SCH_DUAL) begin
      if (top_i == ZERO) begin
        cnt_q  <= ZERO;
        down_q <= 1'b0;
      end else if (!down_q) begin
        if (at_top) begin
          down_q <= 1'b1;
          cnt_q  <= cnt_q - ONE;
        end else begin
          cnt_q  <= cnt_q + ONE;
        end
      end else if (at_bot) begin
        down_q <= 1'b0;
        cnt_q  <= ONE;
      end else begin
        cnt_q  <= cnt_q - ONE;
      end
    end else begin
      down_q <= 1'b0;
      cnt_q  <= at_top ? ZERO : cnt_q + ONE;
    end
  end

  assign cnt_o  = cnt_q;
  assign down_o = down_q;

  AST_RAMP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (scheme_i != SCH_DUAL && cnt_q < top_i) |=> cnt_q == $past(cnt_q) + ONE); // R2
  AST_RAMP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (scheme_i != SCH_DUAL && cnt_q >= top_i) |=> cnt_q == ZERO); // R2
  AST_TURN_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (scheme_i == SCH_DUAL && !down_q && cnt_q == top_i && top_i != ZERO) |=> down_q); // R2
  AST_TURN_AT_BOT: assert property (@(posedge clk) disable iff (!rst_n)
    (scheme_i == SCH_DUAL && down_q && at_bot && top_i != ZERO) |=> (!down_q && cnt_q == ONE)); // R2

endmodule

// File: rtl/pwm_cmp_channel.sv
module pwm_cmp_channel
  import pwm_cmp_pkg::*;
#(
  parameter int W    = 16,
  parameter bit IS_A = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  scheme_e      scheme_i,
  input  logic [3:0]   mode_i,
  input  logic [1:0]   act_i,
  input  logic [W-1:0] cmp_i,
  input  logic [W-1:0] top_i,
  input  logic [W-1:0] cnt_i,
  input  logic         down_i,
  input  logic         force_i,
  output logic         pin_o,
  output logic         oe_o
);
  logic match_ev, bottom_ev, top_cmp, tog_ok, oe;
  logic pin_q;
  act_e act;

  assign match_ev  = (cnt_i == cmp_i);
  assign bottom_ev = (cnt_i == '0);
  assign top_cmp   = (cmp_i == top_i);
  assign tog_ok    = toggle_ok(scheme_i, mode_i, IS_A);
  assign oe        = drives(scheme_i, mode_i, IS_A, act_i);

  always_comb begin
    act = ACT_NONE;
    case (scheme_i)
      SCH_SINGLE: begin
        if (act_i[1]) begin
          if (match_ev && !top_cmp) act = act_i[0] ? ACT_SET : ACT_CLR;
          else if (bottom_ev)       act = act_i[0] ? ACT_CLR : ACT_SET;
        end else if (act_i[0] && tog_ok && match_ev) begin
          act = ACT_TGL;
        end
      end
      SCH_DUAL: begin
        if (act_i[1]) begin
          if (top_cmp) begin
            if (bottom_ev) act = act_i[0] ? ACT_CLR : ACT_SET;
          end else if (match_ev) begin
            act = (down_i ^ act_i[0]) ? ACT_SET : ACT_CLR;
          end
        end else if (act_i[0] && tog_ok && match_ev) begin
          act = ACT_TGL;
        end
      end
      default: begin
        if (match_ev || force_i) begin
          case (act_i)
            2'd1:    act = ACT_TGL;
            2'd2:    act = ACT_CLR;
            2'd3:    act = ACT_SET;
            default: act = ACT_NONE;
          endcase
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  pin_q <= 1'b0;
    else if (oe) pin_q <= apply_act(pin_q, act);
  end

  assign pin_o = pin_q;
  assign oe_o  = oe;

  AST_HOLD_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    !oe |=> $stable(pin_q)); // R5
  AST_FORCE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (scheme_i != SCH_PLAIN && force_i && !match_ev && !bottom_ev) |=> $stable(pin_q)); // R10
  AST_TOP_MATCH_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (scheme_i == SCH_SINGLE && act_i[1] && top_cmp && match_ev && !bottom_ev) |=> $stable(pin_q)); // R8
  AST_PLAIN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (scheme_i == SCH_PLAIN && act_i == 2'd2 && (force_i || match_ev)) |=> !pin_q); // R9

endmodule

// File: rtl/pwm_cmp_unit.sv
module pwm_cmp_unit
  import pwm_cmp_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [3:0]   wave_mode,
  input  logic [W-1:0] top_val,
  input  logic [W-1:0] cmp_a,
  input  logic [W-1:0] cmp_b,
  input  logic [1:0]   act_a,
  input  logic [1:0]   act_b,
  input  logic         force_a,
  input  logic         force_b,
  output logic         pin_a,
  output logic         pin_b,
  output logic         drive_a,
  output logic         drive_b,
  output logic [W-1:0] count,
  output logic         count_down
);
  localparam int NCH = 2;

  scheme_e      scheme;
  logic [W-1:0] cnt;
  logic         down;
  logic [W-1:0] cmp_v [NCH];
  logic [1:0]   act_v [NCH];
  logic         frc_v [NCH];
  logic         pin_v [NCH];
  logic         oe_v  [NCH];

  assign scheme = scheme_of(wave_mode);
  assign cmp_v[0] = cmp_a;   assign cmp_v[1] = cmp_b;
  assign act_v[0] = act_a;   assign act_v[1] = act_b;
  assign frc_v[0] = force_a; assign frc_v[1] = force_b;

  pwm_cmp_counter #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .scheme_i(scheme), .top_i(top_val),
    .cnt_o(cnt), .down_o(down)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    pwm_cmp_channel #(.W(W), .IS_A(i == 0)) u_ch (
      .clk(clk), .rst_n(rst_n), .scheme_i(scheme), .mode_i(wave_mode),
      .act_i(act_v[i]), .cmp_i(cmp_v[i]), .top_i(top_val), .cnt_i(cnt),
      .down_i(down), .force_i(frc_v[i]), .pin_o(pin_v[i]), .oe_o(oe_v[i])
    );
  end

  assign pin_a      = pin_v[0];
  assign pin_b      = pin_v[1];
  assign drive_a    = oe_v[0];
  assign drive_b    = oe_v[1];
  assign count      = cnt;
  assign count_down = down;

endmodule

// File: tb/pwm_cmp_unit_tb.sv
module pwm_cmp_unit_tb;
  localparam int W = 16;
  localparam time TCK = 20ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] wave_mode = '0;
  logic [W-1:0] top_val = '0, cmp_a = '0, cmp_b = '0;
  logic [1:0] act_a = '0, act_b = '0;
  logic force_a = 1'b0, force_b = 1'b0;
  logic pin_a, pin_b, drive_a, drive_b, count_down;
  logic [W-1:0] count;

  always #(TCK/2) clk = ~clk;

  pwm_cmp_unit #(.W(W)) u_dut (.*);

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // independent cycle model
  logic [W-1:0] m_cnt;
  logic m_dn, m_pa, m_pb;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int kind(input logic [3:0] w);
    if (w inside {4'd5, 4'd6, 4'd7, 4'd15}) return 1;
    if (w inside {4'd1, 4'd2, 4'd3, 4'd8, 4'd9, 4'd10, 4'd11, 4'd14}) return 2;
    return 0;
  endfunction

  function automatic bit drv(input logic [3:0] w, input logic [1:0] c, input bit ch_a);
    if (c == 2'd0) return 0;
    if (c >= 2'd2) return 1;
    case (kind(w))
      1: return ch_a && w == 4'd15;
      2: return ch_a && (w == 4'd9 || w == 4'd14);
      default: return 1;
    endcase
  endfunction

  function automatic logic newpin(input logic p, input logic [3:0] w, input logic [1:0] c,
      input bit ch_a, input logic [W-1:0] cnt, input logic dn, input logic [W-1:0] cmp,
      input logic [W-1:0] top, input logic frc);
    bit hit, inv;
    int k;
    if (!drv(w, c, ch_a)) return p;
    k = kind(w);
    hit = (cnt == cmp);
    inv = (c == 2'd3);
    if (k == 0) begin
      if (!(hit || frc)) return p;
      if (c == 2'd1) return ~p;
      return inv;
    end
    if (c == 2'd1) return hit ? ~p : p;
    if (cmp == top) return (cnt == 0) ? !inv : p;
    if (hit) return (k == 2) ? (dn ? !inv : inv) : inv;
    if (k == 1 && cnt == 0) return !inv;
    return p;
  endfunction

  function automatic string pin_tag(input logic [3:0] w);
    case (kind(w))
      1: return "R3";
      2: return "R6";
      default: return "R9";
    endcase
  endfunction

  task automatic model_step();
    logic na, nb;
    na = newpin(m_pa, wave_mode, act_a, 1, m_cnt, m_dn, cmp_a, top_val, force_a);
    nb = newpin(m_pb, wave_mode, act_b, 0, m_cnt, m_dn, cmp_b, top_val, force_b);
    m_pa = na; m_pb = nb;
    if (kind(wave_mode) != 2) begin
      m_dn = 0;
      m_cnt = (m_cnt < top_val) ? m_cnt + 1 : '0;
    end else if (top_val == 0) begin
      m_dn = 0; m_cnt = '0;
    end else if (m_dn) begin
      if (m_cnt == 0) begin m_dn = 0; m_cnt = 1; end
      else m_cnt = m_cnt - 1;
    end else begin
      if (m_cnt >= top_val) begin m_dn = 1; m_cnt = m_cnt - 1; end
      else m_cnt = m_cnt + 1;
    end
  endtask

  task automatic tick();
    model_step();
    @(negedge clk);
    chk(count == m_cnt, "R2 count", count, m_cnt);
    chk(count_down == m_dn, "R2 direction", count_down, m_dn);
    chk(pin_a == m_pa, pin_tag(wave_mode), pin_a, m_pa);
    chk(pin_b == m_pb, pin_tag(wave_mode), pin_b, m_pb);
    chk(drive_a == drv(wave_mode, act_a, 1), "R11 drive_a", drive_a, drv(wave_mode, act_a, 1));
    chk(drive_b == drv(wave_mode, act_b, 0), "R11 drive_b", drive_b, drv(wave_mode, act_b, 0));
  endtask

  task automatic setup(input logic [3:0] w, input logic [1:0] ca, input logic [1:0] cb,
                       input logic [W-1:0] t, input logic [W-1:0] a, input logic [W-1:0] b);
    rst_n = 0;
    wave_mode = w; act_a = ca; act_b = cb; top_val = t; cmp_a = a; cmp_b = b;
    force_a = 0; force_b = 0;
    @(negedge clk);
    @(negedge clk);
    m_cnt = '0; m_dn = 0; m_pa = 0; m_pb = 0;
    rst_n = 1;
  endtask

  typedef struct packed {
    logic [3:0] w; logic [1:0] ca; logic [1:0] cb;
    logic [15:0] t; logic [15:0] a; logic [15:0] b;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{4'd5,  2'd2, 2'd3, 16'd9, 16'd3, 16'd6},
    '{4'd15, 2'd1, 2'd1, 16'd7, 16'd2, 16'd4},
    '{4'd6,  2'd1, 2'd2, 16'd7, 16'd2, 16'd7},
    '{4'd7,  2'd3, 2'd2, 16'd5, 16'd0, 16'd5},
    '{4'd1,  2'd2, 2'd3, 16'd8, 16'd3, 16'd5},
    '{4'd9,  2'd1, 2'd1, 16'd6, 16'd2, 16'd2},
    '{4'd14, 2'd1, 2'd2, 16'd6, 16'd6, 16'd6},
    '{4'd10, 2'd1, 2'd3, 16'd6, 16'd3, 16'd0},
    '{4'd0,  2'd1, 2'd2, 16'd5, 16'd2, 16'd3},
    '{4'd4,  2'd3, 2'd0, 16'd4, 16'd1, 16'd2},
    '{4'd5,  2'd0, 2'd0, 16'd3, 16'd1, 16'd2},
    '{4'd11, 2'd3, 2'd2, 16'd4, 16'd4, 16'd4}
  };

  initial begin
    #(TCK * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic held;
    // R1: reset state
    setup(4'd5, 2'd2, 2'd3, 16'd9, 16'd3, 16'd6);
    rst_n = 0;
    @(negedge clk);
    chk(count == 0 && count_down == 0, "R1 counter", count, 0);
    chk(pin_a == 0 && pin_b == 0, "R1 pins", {pin_a, pin_b}, 0);

    for (int v = 0; v < NV; v++) begin
      setup(VECS[v].w, VECS[v].ca, VECS[v].cb, VECS[v].t, VECS[v].a, VECS[v].b);
      for (int c = 0; c < 40; c++) tick();
    end

    // R2: dual-slope sequence with top 3
    setup(4'd1, 2'd2, 2'd2, 16'd3, 16'd1, 16'd2);
    begin
      int seq [7] = '{1, 2, 3, 2, 1, 0, 1};
      for (int i = 0; i < 7; i++) begin
        tick();
        chk(count == seq[i], "R2 dual sequence", count, seq[i]);
      end
    end

    // R4: toggle on A only in mode 15
    setup(4'd5, 2'd1, 2'd1, 16'd3, 16'd1, 16'd1);
    for (int i = 0; i < 10; i++) tick();
    chk(drive_a == 0 && pin_a == 0, "R4 mode5 A undriven", pin_a, 0);
    setup(4'd15, 2'd1, 2'd1, 16'd3, 16'd1, 16'd1);
    tick(); tick();
    chk(pin_a == 1 && drive_a == 1, "R4 mode15 A toggled", pin_a, 1);
    chk(drive_b == 0 && pin_b == 0, "R4 B never toggles", pin_b, 0);

    // R7: dual toggle permission
    setup(4'd1, 2'd1, 2'd1, 16'd4, 16'd1, 16'd1);
    tick();
    chk(drive_a == 0, "R7 mode1 A undriven", drive_a, 0);
    setup(4'd9, 2'd1, 2'd1, 16'd4, 16'd1, 16'd1);
    tick(); tick();
    chk(drive_a == 1 && pin_a == 1, "R7 mode9 A toggles", pin_a, 1);
    chk(drive_b == 0, "R7 B undriven", drive_b, 0);

    // R8: compare equal to top
    setup(4'd5, 2'd2, 2'd3, 16'd5, 16'd5, 16'd5);
    for (int i = 0; i < 14; i++) begin
      tick();
      chk(pin_a == 1 && pin_b == 0, "R8 fast top compare", {pin_a, pin_b}, 2);
    end
    setup(4'd2, 2'd2, 2'd3, 16'd4, 16'd4, 16'd4);
    for (int i = 0; i < 14; i++) begin
      tick();
      chk(pin_a == 1 && pin_b == 0, "R8 dual top compare", {pin_a, pin_b}, 2);
    end

    // R5: action 0 holds level
    setup(4'd0, 2'd0, 2'd0, 16'd3, 16'd1, 16'd1);
    force_a = 1; force_b = 1;
    tick(); tick();
    force_a = 0; force_b = 0;
    chk(pin_a == 0 && pin_b == 0 && drive_a == 0, "R5 undriven hold", {pin_a, pin_b}, 0);

    // R10: force in plain mode toggles without disturbing the counter
    setup(4'd0, 2'd1, 2'd2, 16'd100, 16'd50, 16'd50);
    tick(); tick();
    force_a = 1;
    tick();
    force_a = 0;
    chk(pin_a == 1, "R10 plain force toggles", pin_a, 1);
    chk(count == 3, "R10 counter unaffected", count, 3);
    tick();
    chk(pin_a == 1 && count == 4, "R10 single pulse", pin_a, 1);

    // R10: force ignored in PWM
    setup(4'd5, 2'd2, 2'd2, 16'd100, 16'd50, 16'd50);
    tick(); tick();
    held = pin_a;
    force_a = 1; force_b = 1;
    tick();
    force_a = 0; force_b = 0;
    chk(pin_a == held && pin_a == 1, "R10 PWM force ignored", pin_a, 1);

    // R9: plain set action via match
    setup(4'd12, 2'd3, 2'd1, 16'd6, 16'd2, 16'd2);
    for (int i = 0; i < 4; i++) tick();
    chk(pin_a == 1 && pin_b == 1, "R9 plain set and toggle", {pin_a, pin_b}, 3);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule